// File: doc/BRIEF.md
# Microwire serial EEPROM slave

This block is a synthesizable, pin-level model of a 1 Kbit three-wire serial EEPROM. An external master drives chip select, a serial clock and a serial data input. The block returns serial data on a data output that has a separate drive enable, so the pad can be placed in high-Z. A static organization input selects the array shape: 64 words of 16 bits, or 128 bytes of 8 bits.

Every transaction begins with a start bit. A two-bit opcode follows, then the address, then any write data. Read data streams out after a single leading zero. While chip select stays high, reading continues through the following addresses. The programming instructions are erase, write, erase-all and write-all. Each one starts a program cycle that times itself and is counted in system clocks. While such a cycle runs, the master can raise chip select to poll a busy/ready flag on the data output. A write-enable latch guards all programming.

The block runs from a fast system clock. The three serial inputs pass through two-flop synchronizers, and the block finds serial clock edges by comparing successive samples.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the data output is not driven, programming is disabled, and every array bit reads 1.
- R2: The block ignores serial clock edges until the first rising edge with chip select high and data input high. That edge is the start bit, so any zeros clocked in before it have no effect.
- R3: The two bits after the start bit select the instruction. 10 is read, 01 is write, 11 is erase. 00 takes its sub-code from the two most significant address bits: 11 enables programming, 00 disables it, 10 erases all, and 01 writes all. The other address bits are ignored.
- R4: With organization input 1, addresses are 6 bits and words are 16 bits. With organization input 0, addresses are 7 bits and data is 8 bits. Byte address a lies in 16-bit word a>>1: bits 15:8 when a[0]=1, and bits 7:0 when a[0]=0.
- R5: A read drives one 0 bit on the rising edge that samples the last address bit. The data then follows MSB first, one bit per later rising edge. All serial bits are sampled on rising edges.
- R6: While chip select stays high, a read continues with the next address, with no further leading zero. The address wraps from the top of the array to 0.
- R7: Erase, write, erase-all and write-all have no effect unless the enable sub-code has been executed since reset or since the last disable sub-code. Reads are unaffected by this state.
- R8: Erase sets the addressed word (or byte) to all ones. Write replaces it with the shifted-in data, and leaves all other locations unchanged.
- R9: Erase-all sets every bit to 1. Write-all stores the shifted-in data in every word, or in every byte when the organization input is 0.
- R10: A program cycle starts only on the chip-select fall that follows the last required bit. If chip select falls before that bit, nothing is executed.
- R11: The data output is driven only while chip select is high. During a program cycle it shows 0. After the cycle ends it shows 1. An erase or write cycle lasts PROG_CLKS system clocks, erase-all lasts twice that, and write-all four times.
- R12: Start bits are ignored while a program cycle runs. Clock edges after the last required bit of an instruction are ignored until chip select falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, asynchronous, active high |
| sclk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data input |
| org_i | input | 1 | Organization: 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data output value |
| do_oe_o | output | 1 | Drive enable for do_o; 0 means high-Z |

## Verification
The assertions rely on several properties of the inputs. Each serial clock half period must be longer than the synchronizer and edge-detect latency. Data input must be stable around each rising edge, and the organization input may change only while chip select is low. The bench holds each half period for five system clocks and sets the data bit while the clock is low. It changes the organization input only between transactions, with chip select low, and it keeps chip select high during program cycles long enough to sample both busy and ready.

// File: rtl/mw_pkg.sv
// Shared types and instruction codes for the serial EEPROM slave.
// Assumes: the opcode field is two bits wide and the sub-code is the top two address bits.
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE,
        ST_BUSY
    } mw_state_e;

    typedef enum logic [2:0] {
        PG_NONE,
        PG_ERASE,
        PG_WRITE,
        PG_ERALL,
        PG_WRALL
    } mw_prog_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] OPC_EXT   = 2'b00;

    localparam logic [1:0] SUB_WEN   = 2'b11;
    localparam logic [1:0] SUB_WDIS  = 2'b00;
    localparam logic [1:0] SUB_ERALL = 2'b10;
    localparam logic [1:0] SUB_WRALL = 2'b01;

endpackage

// File: rtl/mw_sync.sv
// Two-flop synchronizer for a group of asynchronous inputs.
// Assumes: each bit is independent; the group is not sampled as a coherent word.
module mw_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;

    // Two register stages per bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end

endmodule

// File: rtl/mw_prog_timer.sv
// Down-counter that times one self-timed program cycle.
// Assumes: start is not raised while the counter is running; len is nonzero.
module mw_prog_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [TW-1:0] len_i,
    output logic          busy_o,
    output logic          done_o
);

    logic [TW-1:0] cnt_q;

    // Load the cycle length on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= len_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == TW'(1));

    // R11: a started cycle is running on the next clock.
    a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R11: the counter only decreases by one while running.
    a_r11_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && !$past(start_i)) |-> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/mw_word_array.sv
// Register-based storage array with one combinational read port and a masked
// write port that can hit one word or every word at once.
// Assumes: reset leaves the array in the erased (all ones) state.
module mw_word_array #(
    parameter int WORD_W = 16,
    parameter int AW     = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_idx_i,
    output logic [WORD_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic              wr_all_i,
    input  logic [AW-1:0]     wr_idx_i,
    input  logic [WORD_W-1:0] wr_mask_i,
    input  logic [WORD_W-1:0] wr_data_i
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Masked update of the selected word, or of all words.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '1;
            end else if (wr_en_i && (wr_all_i || (wr_idx_i == AW'(i)))) begin
                mem_q[i] <= (mem_q[i] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
            end
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/mw_eeprom_slave.sv
// Pin-level serial EEPROM slave: start detection, instruction decode, read
// streaming with a leading zero, write-enable latch and self-timed programming
// with busy/ready polling.
// Assumes: org_i changes only while cs_i is low; serial clock half periods
// span several system clocks so every edge is seen after synchronization.
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 6,
    parameter int PROG_CLKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic di_i,
    input  logic org_i,
    output logic do_o,
    output logic do_oe_o
);

    localparam int BYTE_W  = WORD_W / 2;
    localparam int BADDR_W = ADDR_W + 1;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int TW      = $clog2(4 * PROG_CLKS + 1);

    logic cs_s, sclk_s, di_s;
    logic cs_d, sclk_d;
    logic rise, cs_fall;

    mw_state_e            state_q;
    mw_prog_e             pend_q;
    logic [1:0]           opc_q;
    logic [CNT_W-1:0]     bcnt_q;
    logic [BADDR_W-1:0]   addr_q;
    logic [WORD_W-1:0]    data_q;
    logic [WORD_W-1:0]    rd_sh_q;
    logic                 out_bit_q;
    logic                 wen_q;
    logic                 rdy_q;

    logic [CNT_W-1:0]     aw, dw;
    logic [BADDR_W-1:0]   amask, addr_in, addr_inc, rd_addr;
    logic [1:0]           sub;
    logic [ADDR_W-1:0]    rd_idx, wr_idx;
    logic [WORD_W-1:0]    rd_word, rd_aligned;
    logic                 go;
    logic [TW-1:0]        tmr_len;
    logic                 tmr_busy, tmr_done;
    logic                 wr_all;
    logic [WORD_W-1:0]    wr_mask, wr_data;

    mw_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sclk_i, di_i}),
        .sync_o  ({cs_s, sclk_s, di_s})
    );

    // Previous synchronized samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign rise    = sclk_s & ~sclk_d;
    assign cs_fall = cs_d & ~cs_s;

    // Organization-dependent field lengths and address shaping.
    always_comb begin
        aw       = org_i ? CNT_W'(ADDR_W) : CNT_W'(BADDR_W);
        dw       = org_i ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
        amask    = org_i ? {1'b0, {ADDR_W{1'b1}}} : {BADDR_W{1'b1}};
        addr_in  = {addr_q[BADDR_W-2:0], di_s} & amask;
        addr_inc = (addr_q + BADDR_W'(1)) & amask;
        sub      = org_i ? addr_in[ADDR_W-1 -: 2] : addr_in[BADDR_W-1 -: 2];
        rd_addr  = (state_q == ST_ADDR) ? addr_in : addr_inc;
        rd_idx   = org_i ? rd_addr[ADDR_W-1:0] : rd_addr[BADDR_W-1:1];
        if (org_i) begin
            rd_aligned = rd_word;
        end else if (rd_addr[0]) begin
            rd_aligned = {rd_word[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}};
        end else begin
            rd_aligned = {rd_word[BYTE_W-1:0], {BYTE_W{1'b0}}};
        end
    end

    // Program cycle launch and its length per instruction.
    always_comb begin
        go = cs_fall && (state_q == ST_DONE) && (pend_q != PG_NONE) && wen_q;
        case (pend_q)
            PG_ERALL: tmr_len = TW'(2 * PROG_CLKS);
            PG_WRALL: tmr_len = TW'(4 * PROG_CLKS);
            default:  tmr_len = TW'(PROG_CLKS);
        endcase
    end

    // Array update applied when the program cycle completes.
    always_comb begin
        wr_all = (pend_q == PG_ERALL) || (pend_q == PG_WRALL);
        wr_idx = org_i ? addr_q[ADDR_W-1:0] : addr_q[BADDR_W-1:1];
        if (org_i || wr_all) begin
            wr_mask = '1;
        end else if (addr_q[0]) begin
            wr_mask = {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
        end else begin
            wr_mask = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
        end
        if ((pend_q == PG_ERASE) || (pend_q == PG_ERALL)) begin
            wr_data = '1;
        end else if (org_i) begin
            wr_data = data_q;
        end else begin
            wr_data = {data_q[BYTE_W-1:0], data_q[BYTE_W-1:0]};
        end
    end

    mw_prog_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (go),
        .len_i   (tmr_len),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );

    mw_word_array #(.WORD_W(WORD_W), .AW(ADDR_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_word),
        .wr_en_i   (tmr_done),
        .wr_all_i  (wr_all),
        .wr_idx_i  (wr_idx),
        .wr_mask_i (wr_mask),
        .wr_data_i (wr_data)
    );

    // Instruction sequencer: start, opcode, address, data, read stream, cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pend_q    <= PG_NONE;
            opc_q     <= 2'b00;
            bcnt_q    <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            rd_sh_q   <= '0;
            out_bit_q <= 1'b0;
            wen_q     <= 1'b0;
            rdy_q     <= 1'b0;
        end else if (cs_fall && (state_q != ST_BUSY)) begin
            rdy_q   <= 1'b0;
            state_q <= go ? ST_BUSY : ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cs_s && rise && di_s) begin
                        state_q <= ST_OPC;
                        pend_q  <= PG_NONE;
                        bcnt_q  <= '0;
                        rdy_q   <= 1'b0;
                    end
                end
                ST_OPC: begin
                    if (rise) begin
                        opc_q <= {opc_q[0], di_s};
                        if (bcnt_q == CNT_W'(1)) begin
                            state_q <= ST_ADDR;
                            bcnt_q  <= '0;
                        end else begin
                            bcnt_q <= bcnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_ADDR: begin
                    if (rise) begin
                        addr_q <= addr_in;
                        if (bcnt_q == aw - CNT_W'(1)) begin
                            bcnt_q <= '0;
                            case (opc_q)
                                OPC_READ: begin
                                    state_q   <= ST_READ;
                                    rd_sh_q   <= rd_aligned;
                                    out_bit_q <= 1'b0;
                                    bcnt_q    <= dw;
                                end
                                OPC_WRITE: begin
                                    state_q <= ST_DATA;
                                    pend_q  <= PG_WRITE;
                                end
                                OPC_ERASE: begin
                                    state_q <= ST_DONE;
                                    pend_q  <= PG_ERASE;
                                end
                                default: begin
                                    case (sub)
                                        SUB_WEN: begin
                                            wen_q   <= 1'b1;
                                            state_q <= ST_DONE;
                                        end
                                        SUB_WDIS: begin
                                            wen_q   <= 1'b0;
                                            state_q <= ST_DONE;
                                        end
                                        SUB_ERALL: begin
                                            pend_q  <= PG_ERALL;
                                            state_q <= ST_DONE;
                                        end
                                        default: begin
                                            pend_q  <= PG_WRALL;
                                            state_q <= ST_DATA;
                                        end
                                    endcase
                                end
                            endcase
                        end else begin
                            bcnt_q <= bcnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_DATA: begin
                    if (rise) begin
                        data_q <= {data_q[WORD_W-2:0], di_s};
                        if (bcnt_q == dw - CNT_W'(1)) begin
                            state_q <= ST_DONE;
                        end else begin
                            bcnt_q <= bcnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_READ: begin
                    if (rise) begin
                        if (bcnt_q != '0) begin
                            out_bit_q <= rd_sh_q[WORD_W-1];
                            rd_sh_q   <= rd_sh_q << 1;
                            bcnt_q    <= bcnt_q - CNT_W'(1);
                        end else begin
                            addr_q    <= addr_inc;
                            out_bit_q <= rd_aligned[WORD_W-1];
                            rd_sh_q   <= rd_aligned << 1;
                            bcnt_q    <= dw - CNT_W'(1);
                        end
                    end
                end
                ST_BUSY: begin
                    if (tmr_done) begin
                        state_q <= ST_IDLE;
                        rdy_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Serial output: read data, busy (0) or ready (1), only with CS high.
    assign do_oe_o = cs_s && ((state_q == ST_READ) || (state_q == ST_BUSY) ||
                              ((state_q == ST_IDLE) && rdy_q));
    assign do_o    = (state_q == ST_READ) ? out_bit_q : ((state_q == ST_IDLE) && rdy_q);

    // R11: never drive the output unless chip select was high two samples ago.
    a_r11_drive_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        do_oe_o |-> $past(cs_i, 2));

    // R11: a running program cycle reports busy as 0.
    a_r11_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy && do_oe_o) |-> !do_o);

    // R5: the rising edge of the last read address bit yields a driven zero.
    a_r5_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ADDR) && rise && !cs_fall && (opc_q == OPC_READ) &&
         (bcnt_q == aw - CNT_W'(1))) |=> ((state_q == ST_READ) && !do_o));

    // R7: the array is never updated while programming is disabled.
    a_r7_no_prog_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> wen_q);

    // R12: the sequencer stays in the program cycle until the timer finishes.
    a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BUSY) && !tmr_done) |=> (state_q == ST_BUSY));

    // R10: a program cycle only begins from a completed instruction.
    a_r10_cycle_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_busy) |-> ($past(state_q) == ST_DONE));

endmodule

// File: tb/mw_eeprom_slave_tb.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every word and byte, programming modes,
// cycle timing and the ignored-input cases against a bench-side model.
module mw_eeprom_slave_tb;

    localparam int T = 200;
    localparam int H = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b1;
    logic dout, doe;
    int   n_chk = 0, n_err = 0;
    logic [15:0] m [64];

    always #4 clk = ~clk;

    mw_eeprom_slave #(.WORD_W(16), .ADDR_W(6), .PROG_CLKS(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
        .org_i(org), .do_o(dout), .do_oe_o(doe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        di = b; sclk = 1'b0; wt(H);
        sclk = 1'b1; wt(H);
    endtask

    task automatic cs_hi();
        sclk = 1'b0; cs = 1'b1; wt(4);
    endtask

    task automatic cs_lo();
        sclk = 1'b0; cs = 1'b0; di = 1'b0; wt(8);
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    function automatic int awid();
        return org ? 6 : 7;
    endfunction

    function automatic int dwid();
        return org ? 16 : 8;
    endfunction

    function automatic logic [15:0] mget(input int a);
        if (org) return m[a & 63];
        return (a & 1) ? {8'h00, m[(a & 127) >> 1][15:8]} : {8'h00, m[(a & 127) >> 1][7:0]};
    endfunction

    function automatic void mput(input int a, input logic [15:0] d);
        if (org) m[a & 63] = d;
        else if (a & 1) m[(a & 127) >> 1][15:8] = d[7:0];
        else m[(a & 127) >> 1][7:0] = d[7:0];
    endfunction

    task automatic cmd(input logic [1:0] op, input int a, input int lead);
        cs_hi();
        for (int i = 0; i < lead; i++) sbit(1'b0);
        sbit(1'b1);
        send({14'b0, op}, 2);
        send(16'(a), awid());
    endtask

    task automatic sub_cmd(input logic [1:0] s);
        cmd(2'b00, org ? {s, 4'b0} : {s, 5'b0}, 0);
    endtask

    task automatic wait_ready(input string tag);
        int k = 0;
        cs_hi();
        while (!(doe === 1'b1 && dout === 1'b1) && k < 5000) begin wt(1); k++; end
        chk(k < 5000, tag, k, 5000);
        cs_lo();
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        cmd(2'b01, a, 0);
        send(d, dwid());
        cs_lo();
        wait_ready("R8");
        mput(a, d);
    endtask

    task automatic no_cycle(input string tag);
        cs_hi(); wt(10);
        chk(doe === 1'b0, tag, doe, 0);
        cs_lo();
    endtask

    task automatic rd_check(input int a, input int nw, input int lead, input string tag);
        logic [15:0] v;
        cmd(2'b10, a, lead);
        sclk = 1'b0; wt(H);
        chk(doe === 1'b1 && dout === 1'b0, "R5 leading zero", {doe, dout}, 2'b10);
        sclk = 1'b1; wt(H);
        for (int w = 0; w < nw; w++) begin
            v = '0;
            for (int b = 0; b < dwid(); b++) begin
                sclk = 1'b0; wt(H);
                v = {v[14:0], dout};
                sclk = 1'b1; wt(H);
            end
            chk(v === mget(a + w), tag, v, mget(a + w));
        end
        cs_lo();
    endtask

    task automatic prog_timed(input int len, input string tag);
        cs = 1'b1;
        wt(len * 3 / 4 - 8);
        chk(doe === 1'b1 && dout === 1'b0, tag, {doe, dout}, 2'b10);
        wt(len / 4 + 60);
        chk(doe === 1'b1 && dout === 1'b1, tag, {doe, dout}, 2'b11);
        cs_lo();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) m[i] = 16'hFFFF;
        wt(5); rst_n = 1'b1; wt(5);
        chk(doe === 1'b0, "R1 output released", doe, 0);
        rd_check(0, 2, 0, "R1 erased array");

        // Programming disabled after reset.
        cmd(2'b01, 5, 0); send(16'h1234, 16); cs_lo();
        no_cycle("R7 no cycle when disabled");
        rd_check(5, 1, 0, "R7 word unchanged");

        // Enable, timed first write, then write every word.
        sub_cmd(2'b11); cs_lo();
        cmd(2'b01, 0, 0); send(16'hA5C3, 16); cs_lo();
        prog_timed(T, "R11 write cycle");
        mput(0, 16'hA5C3);
        for (int i = 1; i < 64; i++) wr(i, 16'(i * 16'h0413) ^ 16'hA5C3);
        rd_check(0, 65, 0, "R6 sequential sweep with wrap");
        rd_check(17, 2, 3, "R2 leading zeros ignored");

        // Single-word erase.
        cmd(2'b11, 10, 0); cs_lo(); wait_ready("R8"); mput(10, 16'hFFFF);
        rd_check(9, 3, 0, "R3 R8 erase one word");

        // Truncated write is not executed.
        cmd(2'b01, 20, 0); send(16'h02EF, 10); cs_lo();
        no_cycle("R10 truncated no cycle");
        rd_check(20, 1, 0, "R10 word unchanged");

        // Extra clocks after the data are ignored.
        cmd(2'b01, 21, 0); send(16'h0F0F, 16); sbit(1'b1); sbit(1'b1); sbit(1'b0);
        cs_lo(); wait_ready("R12"); mput(21, 16'h0F0F);
        rd_check(21, 1, 0, "R12 trailing clocks ignored");

        // Start bit during a program cycle is ignored.
        cmd(2'b01, 22, 0); send(16'h7E81, 16); cs_lo();
        cs_hi(); sbit(1'b1); send(16'h0002, 2); send(16'd22, 6);
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b0; wt(H);
            chk(doe === 1'b1 && dout === 1'b0, "R12 start ignored while busy", {doe, dout}, 2'b10);
            sclk = 1'b1; wt(H);
        end
        begin
            int k = 0;
            while (dout !== 1'b1 && k < 5000) begin wt(1); k++; end
            chk(k < 5000, "R11 ready after cycle", k, 5000);
        end
        cs_lo(); mput(22, 16'h7E81);
        rd_check(22, 1, 0, "R12 write after ignored start");

        // Byte organization: full sweep, byte erase and byte write.
        org = 1'b0; wt(4);
        rd_check(0, 129, 0, "R4 byte sweep with wrap");
        cmd(2'b11, 9, 0); cs_lo(); wait_ready("R8"); mput(9, 16'h00FF);
        wr(7, 16'h005A);
        rd_check(6, 4, 0, "R4 byte lanes");
        org = 1'b1; wt(4);
        rd_check(3, 2, 0, "R4 byte lane mapping in words");

        // Erase all and write all, with cycle lengths.
        sub_cmd(2'b10); cs_lo();
        prog_timed(2 * T, "R11 erase-all length");
        for (int i = 0; i < 64; i++) m[i] = 16'hFFFF;
        rd_check(0, 64, 0, "R9 erase all");
        sub_cmd(2'b01); send(16'h3C96, 16); cs_lo();
        prog_timed(4 * T, "R11 write-all length");
        for (int i = 0; i < 64; i++) m[i] = 16'h3C96;
        rd_check(0, 64, 0, "R9 write all");

        // Disable again: programming ignored, reads still work.
        sub_cmd(2'b00); cs_lo();
        cmd(2'b01, 30, 0); send(16'h0000, 16); cs_lo();
        no_cycle("R7 write ignored after disable");
        sub_cmd(2'b10); cs_lo();
        no_cycle("R7 erase-all ignored after disable");
        rd_check(30, 2, 0, "R7 read after disable");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule